// File: doc/BRIEF.md
# Push-Button Light Mode Controller

This block turns a single push button into the enable signal for a group of LEDs that are always switched together. Every press moves the light one step around a fixed loop of four modes: dark, continuously lit, dark again, and blinking. After blinking, the next press returns it to dark and the loop starts again. Because there are two distinct dark modes, presses take turns between the steady and the blinking behaviour.

The raw button level first passes through a two-stage synchronizer. A rising-edge detector then turns each press into a one-cycle advance pulse, so holding the button down counts as one press. A two-bit mode register uses all four codes. A free-running prescaler toggles a blink phase flop at a few hertz. That flop is forced to its lit phase whenever blinking mode is entered. The LED enable is registered.

Top module: `bike_light_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in the first dark mode (code 00), drives `led_en` low and clears the blink prescaler. The first press after reset gives a steady light.
- R2: Each press advances the mode by one code, 00 → 01 → 10 → 11 → 00. The corresponding light behaviours are dark, steady, dark, blinking, and then back to dark.
- R3: A press advances the mode exactly once, however many cycles the button stays held.
- R4: If `btn_raw` goes high just after a clock edge, `led_en` first shows the new mode after the fourth rising edge that follows. The path is two synchronizer stages, the mode register and the output register.
- R5: On every entry into blinking mode, `led_en` starts in its lit phase. It then alternates between exactly HALF_CYC cycles high and HALF_CYC cycles low, where HALF_CYC = CLK_HZ / (2 × BLINK_HZ).
- R6: In steady mode `led_en` is held at 1. In both dark modes it is held at 0. The prescaler has no effect on the output in these three modes.
- R7: The blink half-period is derived from the parameters CLK_HZ and BLINK_HZ. This lets a bench shorten it without changing the logic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Asynchronous push-button level, high while pressed |
| led_en | output | 1 | Registered enable shared by all LEDs |

## Verification
The button is pressed with hold times from one cycle to fifty cycles. This shows whether a long hold is counted once and whether the shortest possible press still gets through the synchronizer. A full walk around the mode loop checks that the two dark modes are kept apart, because the press after each one must give a different light. Blinking mode is entered twice, with other modes in between. Measuring the length of the first lit run each time shows whether the phase restarts on entry or carries over from the free-running prescaler. A reset in the middle of blinking shows whether the loop restarts at the first dark mode.

// File: rtl/bike_light_pkg.sv
package bike_light_pkg;
  typedef enum logic [1:0] {
    MODE_DARK_A = 2'b00,
    MODE_STEADY = 2'b01,
    MODE_DARK_B = 2'b10,
    MODE_BLINK  = 2'b11
  } light_mode_t;

  function automatic light_mode_t step_mode(input light_mode_t cur);
    return light_mode_t'(cur + 2'd1);
  endfunction
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/press_detect.sv
module press_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (rst) level_d <= 1'b0;
    else     level_d <= level;
  end

  assign pulse = level & ~level_d;
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import bike_light_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        advance,
  output light_mode_t mode,
  output logic        enter_blink
);
  always_ff @(posedge clk) begin
    if (rst)          mode <= MODE_DARK_A;
    else if (advance) mode <= step_mode(mode);
  end

  assign enter_blink = advance && (mode == MODE_DARK_B);
endmodule

// File: rtl/blink_divider.sv
module blink_divider #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic phase
);
  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      phase <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      phase <= ~phase;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bike_light_ctrl.sv
module bike_light_ctrl
  import bike_light_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int BLINK_HZ    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic led_en
);
  localparam int HALF_RAW = CLK_HZ / (2 * BLINK_HZ);
  localparam int HALF_CYC = (HALF_RAW < 2) ? 2 : HALF_RAW;

  logic        btn_s;
  logic        press_pulse;
  logic        enter_blink;
  logic        blink_phase;
  light_mode_t mode_q;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(btn_raw), .dout(btn_s)
  );

  press_detect u_edge (
    .clk(clk), .rst(rst), .level(btn_s), .pulse(press_pulse)
  );

  mode_fsm u_fsm (
    .clk(clk), .rst(rst), .advance(press_pulse),
    .mode(mode_q), .enter_blink(enter_blink)
  );

  blink_divider #(.HALF_CYC(HALF_CYC)) u_div (
    .clk(clk), .rst(rst), .restart(enter_blink), .phase(blink_phase)
  );

  // Low code bit marks the lit modes; high bit gates in the blink phase.
  always_ff @(posedge clk) begin
    if (rst) led_en <= 1'b0;
    else     led_en <= mode_q[0] & (~mode_q[1] | blink_phase);
  end
endmodule

// File: rtl/bike_light_chk.sv
module bike_light_chk
  import bike_light_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [1:0]  mode,
  input logic        press,
  input logic        phase,
  input logic        led
);
  // R3
  press_once_chk: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

  // R2
  mode_step_chk: assert property (@(posedge clk) disable iff (rst)
    press |=> mode == 2'($past(mode) + 2'd1));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !press |=> $stable(mode));

  // R6
  dark_led_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DARK_A || mode == MODE_DARK_B) |=> !led);

  // R6
  steady_led_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STEADY) |=> led);

  // R5
  blink_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (press && mode == MODE_DARK_B) |=> (phase && mode == MODE_BLINK));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (mode == MODE_DARK_A && !led));
endmodule

bind bike_light_ctrl bike_light_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode_q), .press(press_pulse),
  .phase(blink_phase), .led(led_en)
);

// File: tb/tb_bike_light_ctrl.sv
module tb_bike_light_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_CLK_HZ   = 80;
  localparam int T_BLINK_HZ = 10;
  localparam int HALF       = T_CLK_HZ / (2 * T_BLINK_HZ);
  localparam int WIN        = 4 * HALF;
  localparam int N_VEC      = 8;
  localparam logic [1:0] CL_DARK = 2'd0, CL_LIT = 2'd1, CL_BLINK = 2'd2;
  // {hold cycles[7:0], expected class[1:0]}, walked starting from steady
  localparam logic [9:0] VEC [N_VEC] = '{
    {8'd20, CL_DARK}, {8'd1, CL_BLINK}, {8'd2, CL_DARK}, {8'd50, CL_LIT},
    {8'd5, CL_DARK},  {8'd4, CL_BLINK}, {8'd9, CL_DARK}, {8'd3, CL_LIT}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic led_en;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bike_light_ctrl #(.CLK_HZ(T_CLK_HZ), .BLINK_HZ(T_BLINK_HZ)) dut (
    .clk(clk), .rst(rst), .btn_raw(btn), .led_en(led_en)
  );

  task automatic wrap_up();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic classify(output logic [1:0] cls);
    int hi = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (led_en) hi++;
    end
    cls = (hi == 0) ? CL_DARK : (hi == WIN) ? CL_LIT : CL_BLINK;
  endtask

  task automatic press(input int hold);
    @(negedge clk) btn = 1'b1;
    repeat (hold) @(negedge clk);
    btn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic measure_blink(output int hi_run, output int lo_run);
    int guard = 0;
    @(negedge clk) btn = 1'b1;
    while (!led_en && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    btn = 1'b0;
    hi_run = 0;
    while (led_en && hi_run < 50) begin
      hi_run++;
      @(negedge clk);
    end
    lo_run = 0;
    while (!led_en && lo_run < 50) begin
      lo_run++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    wrap_up();
  end

  initial begin
    logic [1:0] cls;
    int hi_r, lo_r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: dark after reset
    check(led_en == 1'b0, "R1 reset output", led_en, 0);
    classify(cls);
    check(cls == CL_DARK, "R1 dark after reset", cls, CL_DARK);

    // R4: latency of first press, which also yields steady (R1)
    @(negedge clk) btn = 1'b1;
    repeat (3) @(negedge clk);
    check(led_en == 1'b0, "R4 before fourth edge", led_en, 0);
    @(negedge clk);
    check(led_en == 1'b1, "R4 R1 at fourth edge", led_en, 1);
    btn = 1'b0;
    repeat (8) @(negedge clk);

    // R2 R3 R6: walk the loop with varied hold lengths
    for (int v = 0; v < N_VEC; v++) begin
      press(int'(VEC[v][9:2]));
      classify(cls);
      check(cls == VEC[v][1:0], $sformatf("R2 R3 R6 vector %0d", v), cls, VEC[v][1:0]);
    end

    // R5 R7: blink timing on entry (now steady -> dark -> blink)
    press(2);
    measure_blink(hi_r, lo_r);
    check(hi_r == HALF, "R5 R7 first lit run", hi_r, HALF);
    check(lo_r == HALF, "R5 R7 first dark run", lo_r, HALF);

    // R5: phase restarts on a later entry (blink -> dark -> steady -> dark -> blink)
    repeat (3) @(negedge clk);
    press(2);
    press(3);
    press(2);
    measure_blink(hi_r, lo_r);
    check(hi_r == HALF, "R5 re-entry lit run", hi_r, HALF);
    check(lo_r == HALF, "R5 re-entry dark run", lo_r, HALF);

    // R1: reset during blink restarts the loop at the first dark mode
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    classify(cls);
    check(cls == CL_DARK, "R1 reset mid-blink", cls, CL_DARK);
    press(4);
    classify(cls);
    check(cls == CL_LIT, "R1 first press after reset", cls, CL_LIT);

    wrap_up();
  end
endmodule